// File: doc/BRIEF.md
# Instruction Fetch Security Monitor

This block sits between the CPU's memory read path and the memories. It watches each CPU transaction and decides whether the access is legal. When an access breaks a rule, the block returns all-zero data to the CPU in place of the memory word. The CPU decodes an all-zero word as an illegal opcode. Three rules apply:

- An instruction fetch from the firmware RAM is always illegal.
- Any access that falls inside the main RAM address span but above the populated RAM is always illegal.
- An instruction fetch inside an application-defined no-execute window is illegal once that window has been armed.

An application programs the two inclusive window bounds through a small register interface and then arms the window. From then on neither the bounds nor the armed state can change until reset. The block also watches the CPU's trap indicator. Once a trap is seen, the block takes over the RGB LED outputs and flashes red at a rate set by a counter parameter. It keeps flashing until reset.

Top module: `fetch_guard`

## Requirements
- R1: After reset the window is disarmed, both bounds read back as zero, `led_out` equals `led_in`, and `cpu_rdata` equals `mem_rdata`.
- R2: With `reg_cs` high and `reg_we` low, `reg_rdata` returns a value chosen by `reg_addr`: offset 0x60 gives the armed flag in bit 0 (upper bits zero), 0x61 gives the first (lower) bound and 0x62 gives the last (upper) bound. Any other offset reads as zero.
- R3: A write to offset 0x60 with bit 0 set arms the window. A write with bit 0 clear has no effect. Once armed, the window stays armed until reset.
- R4: While disarmed, writes to 0x61 and 0x62 load the bounds. Once armed, writes to them are ignored and the bounds read back unchanged.
- R5: A valid fetch (`cpu_fetch`=1) whose address lies from FW_BASE to FW_BASE+FW_SIZE-1 returns zero on `cpu_rdata`. Data reads in that range pass through.
- R6: A valid access of either kind whose address lies from RAM_BASE+RAM_SIZE to RAM_BASE+RAM_SPAN-1 returns zero. The address RAM_BASE+RAM_SIZE-1 and the address RAM_BASE+RAM_SPAN are not affected by this rule.
- R7: When armed, a valid fetch whose byte address lies from the first bound to the last bound, both inclusive, returns zero. Data reads there pass through, and nothing in the window is blocked while disarmed.
- R8: In every other case, including `cpu_valid` low, `cpu_rdata` equals `mem_rdata` in the same cycle.
- R9: A high `cpu_trap` at a clock edge latches the trapped state until reset, whatever `cpu_trap` does afterwards. While trapped, `led_out[1:0]` (green, blue) is zero. `led_out[2]` (red) is 1 for the first 2^FLASH_BITS cycles after the latching edge and then inverts every 2^FLASH_BITS cycles.
- R10: Before a trap, `led_out` equals `led_in`, bit-for-bit: bit 2 red, bit 1 green, bit 0 blue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_cs | input | 1 | Register access select |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 8 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| cpu_valid | input | 1 | CPU transaction valid |
| cpu_fetch | input | 1 | 1 for instruction fetch, 0 for data access |
| cpu_addr | input | 32 | CPU byte address |
| mem_rdata | input | 32 | Read data from the memories |
| cpu_rdata | output | 32 | Read data returned to the CPU |
| cpu_trap | input | 1 | CPU has entered its trap state |
| led_in | input | 3 | LED register value {red, green, blue} |
| led_out | output | 3 | LED drive {red, green, blue} |

## Verification
The bench builds the block with RAM_SIZE shrunk to 0x1000 and FLASH_BITS set to 4. The small RAM size lets random addresses land on both sides of the populated-RAM edge often. The 16-cycle flash half-period lets the bench sample several red inversions right at their boundary cycles. The firmware base and the main RAM span keep their defaults, so the span's top edge at 0x7FFFFFFF is tested against the first address beyond it.

// File: rtl/fetch_guard.sv
module fetch_guard #(
  parameter logic [31:0] FW_BASE    = 32'hD000_0000,
  parameter logic [31:0] FW_SIZE    = 32'h0000_0800,
  parameter logic [31:0] RAM_BASE   = 32'h4000_0000,
  parameter logic [31:0] RAM_SPAN   = 32'h4000_0000,
  parameter logic [31:0] RAM_SIZE   = 32'h0002_0000,
  parameter int          FLASH_BITS = 19
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_cs,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        cpu_valid,
  input  logic        cpu_fetch,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] mem_rdata,
  output logic [31:0] cpu_rdata,
  input  logic        cpu_trap,
  input  logic [2:0]  led_in,
  output logic [2:0]  led_out
);
  localparam logic [7:0]  OFS_CTRL = 8'h60;
  localparam logic [7:0]  OFS_LO   = 8'h61;
  localparam logic [7:0]  OFS_HI   = 8'h62;
  localparam logic [31:0] FW_LAST  = FW_BASE + FW_SIZE - 32'd1;
  localparam logic [31:0] OOB_LO   = RAM_BASE + RAM_SIZE;
  localparam logic [31:0] OOB_HI   = RAM_BASE + RAM_SPAN - 32'd1;

  logic                  armed;
  logic [31:0]           win_lo, win_hi;
  logic                  trapped;
  logic                  flash_red;
  logic [FLASH_BITS-1:0] flash_cnt;

  wire wr = reg_cs & reg_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      win_lo <= '0;
      win_hi <= '0;
    end else begin
      if (wr && reg_addr == OFS_CTRL && reg_wdata[0]) armed <= 1'b1;
      if (wr && !armed && reg_addr == OFS_LO) win_lo <= reg_wdata;
      if (wr && !armed && reg_addr == OFS_HI) win_hi <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_cs && !reg_we) begin
      case (reg_addr)
        OFS_CTRL: reg_rdata = {31'd0, armed};
        OFS_LO:   reg_rdata = win_lo;
        OFS_HI:   reg_rdata = win_hi;
        default:  reg_rdata = '0;
      endcase
    end
  end

  wire in_fw   = (cpu_addr >= FW_BASE) && (cpu_addr <= FW_LAST);
  wire in_oob  = (cpu_addr >= OOB_LO) && (cpu_addr <= OOB_HI);
  wire in_win  = (cpu_addr >= win_lo) && (cpu_addr <= win_hi);
  wire blocked = cpu_valid & ((cpu_fetch & in_fw) | in_oob | (armed & cpu_fetch & in_win));

  assign cpu_rdata = blocked ? 32'd0 : mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trapped   <= 1'b0;
      flash_red <= 1'b0;
      flash_cnt <= '0;
    end else if (!trapped) begin
      if (cpu_trap) begin
        trapped   <= 1'b1;
        flash_red <= 1'b1;
        flash_cnt <= '0;
      end
    end else begin
      flash_cnt <= flash_cnt + FLASH_BITS'(1);
      if (&flash_cnt) flash_red <= ~flash_red;
    end
  end

  assign led_out = trapped ? {flash_red, 2'b00} : led_in;
endmodule

// File: rtl/fetch_guard_chk.sv
module fetch_guard_chk #(
  parameter logic [31:0] FW_BASE    = 32'hD000_0000,
  parameter logic [31:0] FW_SIZE    = 32'h0000_0800,
  parameter logic [31:0] RAM_BASE   = 32'h4000_0000,
  parameter logic [31:0] RAM_SPAN   = 32'h4000_0000,
  parameter logic [31:0] RAM_SIZE   = 32'h0002_0000,
  parameter int          FLASH_BITS = 19
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cpu_valid,
  input logic                  cpu_fetch,
  input logic [31:0]           cpu_addr,
  input logic [31:0]           mem_rdata,
  input logic [31:0]           cpu_rdata,
  input logic [2:0]            led_out,
  input logic                  armed,
  input logic [31:0]           win_lo,
  input logic [31:0]           win_hi,
  input logic                  trapped,
  input logic [FLASH_BITS-1:0] flash_cnt
);
  localparam logic [31:0] FW_LAST = FW_BASE + FW_SIZE - 32'd1;
  localparam logic [31:0] OOB_LO  = RAM_BASE + RAM_SIZE;
  localparam logic [31:0] OOB_HI  = RAM_BASE + RAM_SPAN - 32'd1;

  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n) armed |=> armed); // R3
  AST_BOUNDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) armed |=> ($stable(win_lo) && $stable(win_hi))); // R4
  AST_FW_FETCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (cpu_valid && cpu_fetch && cpu_addr >= FW_BASE && cpu_addr <= FW_LAST) |-> cpu_rdata == 32'd0); // R5
  AST_OOB_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (cpu_valid && cpu_addr >= OOB_LO && cpu_addr <= OOB_HI) |-> cpu_rdata == 32'd0); // R6
  AST_WIN_FETCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (cpu_valid && cpu_fetch && armed && cpu_addr >= win_lo && cpu_addr <= win_hi) |-> cpu_rdata == 32'd0); // R7
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n) !cpu_valid |-> cpu_rdata == mem_rdata); // R8
  AST_TRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n) trapped |=> trapped); // R9
  AST_FLASH_GB_OFF: assert property (@(posedge clk) disable iff (!rst_n) trapped |-> led_out[1:0] == 2'b00); // R9
  AST_RED_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (trapped && $past(trapped) && led_out[2] != $past(led_out[2])) |-> $past(&flash_cnt)); // R9
endmodule

bind fetch_guard fetch_guard_chk #(
  .FW_BASE(FW_BASE), .FW_SIZE(FW_SIZE), .RAM_BASE(RAM_BASE),
  .RAM_SPAN(RAM_SPAN), .RAM_SIZE(RAM_SIZE), .FLASH_BITS(FLASH_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_fetch(cpu_fetch),
  .cpu_addr(cpu_addr), .mem_rdata(mem_rdata), .cpu_rdata(cpu_rdata),
  .led_out(led_out), .armed(armed), .win_lo(win_lo), .win_hi(win_hi),
  .trapped(trapped), .flash_cnt(flash_cnt)
);

// File: tb/tb_fetch_guard.sv
module tb_fetch_guard;
  localparam logic [31:0] FWB  = 32'hD000_0000;
  localparam logic [31:0] FWS  = 32'h0000_0800;
  localparam logic [31:0] RB   = 32'h4000_0000;
  localparam logic [31:0] SPAN = 32'h4000_0000;
  localparam logic [31:0] RS   = 32'h0000_1000;
  localparam int          FB   = 4;
  localparam logic [31:0] WLO  = RB + 32'h100;
  localparam logic [31:0] WHI  = RB + 32'h1FF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_cs = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic cpu_valid = 1'b0, cpu_fetch = 1'b0, cpu_trap = 1'b0;
  logic [31:0] cpu_addr = '0, mem_rdata = '0, cpu_rdata;
  logic [2:0] led_in = '0, led_out;

  int n_chk = 0, n_fail = 0;
  logic m_armed = 1'b0;
  logic [31:0] m_lo = '0, m_hi = '0;

  always #4 clk = ~clk;

  fetch_guard #(.FW_BASE(FWB), .FW_SIZE(FWS), .RAM_BASE(RB), .RAM_SPAN(SPAN),
                .RAM_SIZE(RS), .FLASH_BITS(FB)) dut (
    .clk(clk), .rst_n(rst_n), .reg_cs(reg_cs), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_valid(cpu_valid),
    .cpu_fetch(cpu_fetch), .cpu_addr(cpu_addr), .mem_rdata(mem_rdata),
    .cpu_rdata(cpu_rdata), .cpu_trap(cpu_trap), .led_in(led_in), .led_out(led_out));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic valid, input logic fetch,
                                         input logic [31:0] a, input logic [31:0] mem);
    logic fw, oob, win;
    fw  = fetch && a >= FWB && a <= FWB + FWS - 32'd1;
    oob = a >= RB + RS && a <= RB + SPAN - 32'd1;
    win = m_armed && fetch && a >= m_lo && a <= m_hi;
    return (valid && (fw || oob || win)) ? 32'd0 : mem;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_cs = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_cs = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_cs = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 chk(req, reg_rdata, exp);
    reg_cs = 1'b0;
  endtask

  task automatic acc(input string req, input logic v, input logic f, input logic [31:0] a);
    logic [31:0] m;
    m = $urandom() | 32'h1;
    @(negedge clk);
    cpu_valid = v; cpu_fetch = f; cpu_addr = a; mem_rdata = m;
    #1 chk(req, cpu_rdata, exp_rd(v, f, a, m));
    cpu_valid = 1'b0;
  endtask

  function automatic logic [31:0] pick_addr();
    case ($urandom() % 6)
      0: return FWB - 32'h400 + ($urandom() % 32'h1000);
      1: return RB + ($urandom() % (RS * 2));
      2: return RB + SPAN - 32'h8 + ($urandom() % 16);
      3: return WLO - 32'h4 + ($urandom() % (WHI - WLO + 32'd9));
      4: return RB + RS - 32'h2 + ($urandom() % 4);
      default: return $urandom();
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    led_in = 3'b101;
    #1 chk("R1 led passthrough", {29'd0, led_out}, 32'd5);
    rd_chk("R1 ctrl reset", 8'h60, 32'd0);
    rd_chk("R1 lo reset", 8'h61, 32'd0);
    rd_chk("R1 hi reset", 8'h62, 32'd0);
    acc("R1 rdata passthrough", 1'b1, 1'b1, RB);

    wr(8'h61, WLO); m_lo = WLO;
    wr(8'h62, WHI); m_hi = WHI;
    rd_chk("R2 lo readback", 8'h61, WLO);
    rd_chk("R2 hi readback", 8'h62, WHI);
    rd_chk("R2 unmapped offset", 8'h63, 32'd0);
    wr(8'h60, 32'hFFFF_FFFE);
    rd_chk("R3 write without bit0", 8'h60, 32'd0);

    acc("R7 window unarmed", 1'b1, 1'b1, WLO);
    acc("R5 fw first", 1'b1, 1'b1, FWB);
    acc("R5 fw last", 1'b1, 1'b1, FWB + FWS - 32'd1);
    acc("R5 fw past end", 1'b1, 1'b1, FWB + FWS);
    acc("R5 fw data read", 1'b1, 1'b0, FWB + 32'h10);
    acc("R6 ram top valid", 1'b1, 1'b0, RB + RS - 32'd1);
    acc("R6 oob first", 1'b1, 1'b0, RB + RS);
    acc("R6 oob fetch", 1'b1, 1'b1, RB + RS + 32'h40);
    acc("R6 span last", 1'b1, 1'b0, RB + SPAN - 32'd1);
    acc("R6 span beyond", 1'b1, 1'b0, RB + SPAN);
    acc("R8 invalid in fw", 1'b0, 1'b1, FWB);
    for (int i = 0; i < 150; i++) acc("R8 random unarmed", ($urandom() % 4) != 0, $urandom() % 2, pick_addr());

    wr(8'h60, 32'h1); m_armed = 1'b1;
    rd_chk("R3 armed", 8'h60, 32'd1);
    acc("R7 window lo", 1'b1, 1'b1, WLO);
    acc("R7 window hi", 1'b1, 1'b1, WHI);
    acc("R7 below lo", 1'b1, 1'b1, WLO - 32'd1);
    acc("R7 above hi", 1'b1, 1'b1, WHI + 32'd1);
    acc("R7 data in window", 1'b1, 1'b0, WLO + 32'h20);
    for (int i = 0; i < 200; i++) acc("R7 random armed", ($urandom() % 4) != 0, $urandom() % 2, pick_addr());

    wr(8'h61, 32'h0);
    wr(8'h62, 32'hFFFF_FFFF);
    rd_chk("R4 lo frozen", 8'h61, WLO);
    rd_chk("R4 hi frozen", 8'h62, WHI);
    acc("R4 window unchanged", 1'b1, 1'b1, WHI + 32'd4);
    wr(8'h60, 32'h0);
    rd_chk("R3 no disarm", 8'h60, 32'd1);

    led_in = 3'b010;
    #1 chk("R10 led before trap", {29'd0, led_out}, 32'd2);
    led_in = 3'b111;
    @(negedge clk);
    cpu_trap = 1'b1;
    @(negedge clk);
    cpu_trap = 1'b0;
    for (int j = 0; j <= 40; j++) begin
      if (j == 0 || j == 15 || j == 16 || j == 31 || j == 32 || j == 40)
        chk("R9 flash pattern", {29'd0, led_out}, {29'd0, ((j >> FB) % 2 == 0), 2'b00});
      @(negedge clk);
    end
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 led after reset", {29'd0, led_out}, 32'd7);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule